// File: doc/BRIEF.md
# Move-to-Front Table Decoder

This block turns a stream of move-to-front tokens back into the symbols they encode. Each token either names a position in a small recency table (a hit) or carries a symbol in full (a miss). The block keeps its own recency table and updates it for every token under the same rule the matching encoder uses. The two tables therefore stay identical, and a code's meaning follows the history of symbols seen so far.

Tokens arrive on a valid/ready input and symbols leave on a registered valid/ready output. The block takes at most one token per cycle. A stalled output holds its symbol and blocks new tokens. If a hit names a table slot that has never been filled, a sticky flag is raised and the table is left as it was.

Top module: `mtf_table_decoder`

## Requirements
- R1: While reset is high and in the cycle after it falls, `sym_valid` and `bad_code` are 0 and `tok_ready` is 1. Every table slot is empty after reset.
- R2: A miss token (`tok_hit`=0) accepted at a clock edge makes `sym_valid`=1 and `sym_data`=`tok_lit` right after that edge.
- R3: A hit token with code k, where k is the distance from the most recent slot (0 = most recent), makes `sym_data` the symbol in slot k right after the accepting edge.
- R4: After a hit at code k, the symbol from slot k moves to slot 0. Slots 0..k-1 each move one place toward the oldest end. Slots beyond k keep their contents.
- R5: After a miss, every slot moves one place toward the oldest end, the oldest symbol is dropped, and the literal enters slot 0 as a filled slot.
- R6: A hit whose code names an empty slot is consumed, produces no output symbol, sets `bad_code` (which stays 1 until reset), and leaves the table unchanged.
- R7: `tok_ready` is 0 exactly while `sym_valid`=1 and `sym_ready`=0. During such a stall, `sym_data` and `sym_valid` hold their values.
- R8: When the tokens come from a move-to-front encoder of the same depth, the decoder returns the encoder's input sequence exactly, under any pattern of output backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token accepted at the next edge when valid |
| tok_hit | input | 1 | 1 = code names a table slot, 0 = literal |
| tok_code | input | CW | Slot distance from most recent (used on hit) |
| tok_lit | input | SW | Literal symbol (used on miss) |
| sym_valid | output | 1 | Registered output symbol present |
| sym_ready | input | 1 | Sink accepts the symbol |
| sym_data | output | SW | Decoded symbol |
| bad_code | output | 1 | Sticky flag: a hit named an empty slot |

## Verification
Every result is due one register stage after the accepting edge. The symbol, the table update and the error flag all appear right after the edge at which `tok_valid` and `tok_ready` are both high. The bench drives tokens one time unit after a rising edge and reads `tok_ready` one unit after the falling edge. It compares each symbol at the falling edge where `sym_valid` and `sym_ready` are both high, so the value checked is the one transferred at the next rising edge. The flag is checked right after the edge that consumes the offending token. Table effects are observed through the symbols returned by later hits.

// File: rtl/mtf_dec_pkg.sv
package mtf_dec_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_HIT    = 2'd1,
        ACT_MISS   = 2'd2,
        ACT_REJECT = 2'd3
    } act_e;

    function automatic act_e classify(input logic fire, input logic hit, input logic slot_full);
        if (!fire)
            return ACT_NONE;
        else if (!hit)
            return ACT_MISS;
        else if (slot_full)
            return ACT_HIT;
        else
            return ACT_REJECT;
    endfunction

endpackage

// File: rtl/mtf_dec_ctrl.sv
module mtf_dec_ctrl
    import mtf_dec_pkg::*;
(
    input  logic tok_valid,
    input  logic tok_hit,
    input  logic slot_full,
    input  logic out_valid,
    input  logic out_ready,
    output logic tok_ready,
    output act_e act
);
    logic fire;

    always_comb begin
        tok_ready = !out_valid || out_ready;
        fire      = tok_valid && tok_ready;
        act       = classify(fire, tok_hit, slot_full);
    end
endmodule

// File: rtl/mtf_dec_table.sv
module mtf_dec_table
    import mtf_dec_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SW    = 4,
    localparam int CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic [CW-1:0] code,
    input  logic [SW-1:0] lit,
    output logic [SW-1:0] rd_sym,
    output logic          rd_full
);
    logic [SW-1:0]    slot [DEPTH];
    logic [DEPTH-1:0] full;

    always_comb begin
        rd_sym  = '0;
        rd_full = 1'b0;
        if (int'(code) < DEPTH) begin
            rd_sym  = slot[code];
            rd_full = full[code];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            case (act)
                ACT_MISS: begin
                    for (int i = DEPTH - 1; i > 0; i--) begin
                        slot[i] <= slot[i-1];
                        full[i] <= full[i-1];
                    end
                    slot[0] <= lit;
                    full[0] <= 1'b1;
                end
                ACT_HIT: begin
                    for (int i = DEPTH - 1; i > 0; i--) begin
                        if (i <= int'(code)) slot[i] <= slot[i-1];
                    end
                    slot[0] <= rd_sym;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mtf_dec_out.sv
module mtf_dec_out
    import mtf_dec_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic [SW-1:0] hit_sym,
    input  logic [SW-1:0] lit,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [SW-1:0] out_sym,
    output logic          err_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
            err_flag  <= 1'b0;
        end else begin
            if (act == ACT_HIT || act == ACT_MISS) begin
                out_valid <= 1'b1;
                out_sym   <= (act == ACT_HIT) ? hit_sym : lit;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (act == ACT_REJECT) err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/mtf_table_decoder.sv
module mtf_table_decoder
    import mtf_dec_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SW    = 4,
    localparam int CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_valid,
    output logic          tok_ready,
    input  logic          tok_hit,
    input  logic [CW-1:0] tok_code,
    input  logic [SW-1:0] tok_lit,
    output logic          sym_valid,
    input  logic          sym_ready,
    output logic [SW-1:0] sym_data,
    output logic          bad_code
);
    act_e          act;
    logic [SW-1:0] rd_sym;
    logic          rd_full;

    mtf_dec_ctrl u_ctrl (
        .tok_valid (tok_valid),
        .tok_hit   (tok_hit),
        .slot_full (rd_full),
        .out_valid (sym_valid),
        .out_ready (sym_ready),
        .tok_ready (tok_ready),
        .act       (act)
    );

    mtf_dec_table #(.DEPTH(DEPTH), .SW(SW)) u_table (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .code    (tok_code),
        .lit     (tok_lit),
        .rd_sym  (rd_sym),
        .rd_full (rd_full)
    );

    mtf_dec_out #(.SW(SW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .hit_sym   (rd_sym),
        .lit       (tok_lit),
        .out_ready (sym_ready),
        .out_valid (sym_valid),
        .out_sym   (sym_data),
        .err_flag  (bad_code)
    );
endmodule

// File: rtl/mtf_dec_chk.sv
module mtf_dec_chk #(
    parameter int SW = 4,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_valid,
    input logic          tok_ready,
    input logic          tok_hit,
    input logic [CW-1:0] tok_code,
    input logic [SW-1:0] tok_lit,
    input logic          sym_valid,
    input logic          sym_ready,
    input logic [SW-1:0] sym_data,
    input logic          bad_code
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !sym_valid && !bad_code); // R1

    AST_MISS_LITERAL: assert property (@(posedge clk) disable iff (rst)
        tok_valid && tok_ready && !tok_hit |=> sym_valid && sym_data == $past(tok_lit)); // R2

    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
        bad_code |=> bad_code); // R6

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        sym_valid && !sym_ready |-> !tok_ready); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sym_valid && !sym_ready |=> sym_valid && $stable(sym_data)); // R7
endmodule

bind mtf_table_decoder mtf_dec_chk #(.SW(SW), .CW(CW)) u_chk (.*);

// File: tb/tb_mtf_table_decoder.sv
module tb_mtf_table_decoder;
    localparam int DEPTH = 4;
    localparam int SW    = 4;
    localparam int CW    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tok_valid = 1'b0;
    logic          tok_ready;
    logic          tok_hit = 1'b0;
    logic [CW-1:0] tok_code = '0;
    logic [SW-1:0] tok_lit = '0;
    logic          sym_valid;
    logic          sym_ready = 1'b1;
    logic [SW-1:0] sym_data;
    logic          bad_code;

    int checks = 0;
    int errors = 0;
    logic bp_on = 1'b0;

    logic [SW-1:0] exp_sym [64];
    int            exp_req [64];
    int wr_ptr = 0;
    int rd_ptr = 0;

    logic [SW-1:0] mt [DEPTH];
    logic          mv [DEPTH];

    mtf_table_decoder #(.DEPTH(DEPTH), .SW(SW)) dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_sym(input logic [SW-1:0] s, input int req);
        exp_sym[wr_ptr % 64] = s;
        exp_req[wr_ptr % 64] = req;
        wr_ptr++;
    endtask

    // output monitor: decides sym_ready, then checks the transfer due at the next edge
    always @(negedge clk) begin
        sym_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
        if (!rst && sym_valid && sym_ready) begin
            checks++;
            if (rd_ptr == wr_ptr) begin
                errors++;
                $display("FAIL R6 actual=%0d expected=no symbol", sym_data);
            end else begin
                if (sym_data !== exp_sym[rd_ptr % 64]) begin
                    errors++;
                    $display("FAIL R%0d actual=%0d expected=%0d", exp_req[rd_ptr % 64],
                             sym_data, exp_sym[rd_ptr % 64]);
                end
                rd_ptr++;
            end
        end
    end

    // R7: tok_ready low exactly when output is stalled
    always @(negedge clk) begin
        #1;
        if (!rst) chk(tok_ready == !(sym_valid && !sym_ready), "R7", tok_ready, !(sym_valid && !sym_ready));
    end

    // called at posedge+1; returns at posedge+1 after the accepting edge
    task automatic send(input logic h, input logic [CW-1:0] c, input logic [SW-1:0] l);
        tok_valid = 1'b1;
        tok_hit   = h;
        tok_code  = c;
        tok_lit   = l;
        do begin
            @(negedge clk);
            #1;
        end while (!tok_ready);
        @(posedge clk);
        #1;
        tok_valid = 1'b0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            mt[i] = '0;
            mv[i] = 1'b0;
        end
    endtask

    // reference move-to-front encoder
    task automatic encode_send(input logic [SW-1:0] s);
        logic h;
        logic [CW-1:0] c;
        h = 1'b0;
        c = '0;
        for (int i = 0; i < DEPTH; i++)
            if (!h && mv[i] && mt[i] == s) begin
                h = 1'b1;
                c = CW'(i);
            end
        if (h) begin
            for (int j = DEPTH - 1; j > 0; j--) if (j <= int'(c)) mt[j] = mt[j-1];
        end else begin
            for (int j = DEPTH - 1; j > 0; j--) begin
                mt[j] = mt[j-1];
                mv[j] = mv[j-1];
            end
            mv[0] = 1'b1;
        end
        mt[0] = s;
        expect_sym(s, 8); // R8 round trip
        send(h, c, h ? '0 : s);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!sym_valid && !bad_code, "R1", {sym_valid, bad_code}, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        #1;
        chk(!sym_valid && !bad_code && tok_ready, "R1", {sym_valid, bad_code, tok_ready}, 1);
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        bp_on = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(rd_ptr == wr_ptr, "R8", rd_ptr, wr_ptr);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R1: empty table after reset, so a hit is rejected; R6 sticky flag
        send(1'b1, 2'd1, 4'd0);
        chk(bad_code == 1'b1, "R6", bad_code, 1);
        expect_sym(4'd9, 2); // R2 literal
        send(1'b0, 2'd0, 4'd9);
        expect_sym(4'd6, 2);
        send(1'b0, 2'd0, 4'd6);      // table 6,9
        send(1'b1, 2'd3, 4'd0);      // R6 empty slot: no output, table kept
        expect_sym(4'd9, 6);         // 9 still at slot 1
        send(1'b1, 2'd1, 4'd0);      // R3
        chk(bad_code == 1'b1, "R6", bad_code, 1);
        drain();

        do_reset();
        chk(bad_code == 1'b0, "R1", bad_code, 0);
        for (int v = 1; v <= 4; v++) begin
            expect_sym(SW'(v), 5);
            send(1'b0, 2'd0, SW'(v)); // table 4,3,2,1
        end
        expect_sym(4'd5, 5);
        send(1'b0, 2'd0, 4'd5);      // R5 drops 1: table 5,4,3,2
        expect_sym(4'd2, 5);
        send(1'b1, 2'd3, 4'd0);      // oldest now 2; table 2,5,4,3
        expect_sym(4'd4, 4);
        send(1'b1, 2'd2, 4'd0);      // R4: table 4,2,5,3
        expect_sym(4'd3, 4);
        send(1'b1, 2'd3, 4'd0);      // slot 3 untouched by prior hit
        expect_sym(4'd3, 3);
        send(1'b1, 2'd0, 4'd0);      // R3 code 0 after move
        chk(bad_code == 1'b0, "R6", bad_code, 0);
        drain();

        // R8: exhaustive triples, first without then with backpressure (R7)
        for (int pass = 0; pass < 2; pass++) begin
            do_reset();
            bp_on = (pass == 1);
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int c = 0; c < 16; c++) begin
                        encode_send(SW'(a));
                        encode_send(SW'(b));
                        encode_send(SW'(c));
                    end
            drain();
            chk(bad_code == 1'b0, "R8", bad_code, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule